// File: doc/BRIEF.md
# Random Number Generator Register Interface

This block puts a random byte source behind a small byte-wide register window. A host on a simple read/write bus can find out that a generator is there, switch it on or off, poll a ready flag and fetch one random byte per read. The bits come from a 16-bit maximal-length LFSR, which stands in for a real entropy source. The LFSR shifts one bit per clock while the block is collecting, so every byte is predictable in test.

A byte is offered only after eight fresh bits have been gathered. Once a byte is ready, collection pauses until the host takes that byte. No bit of the stream is skipped or overwritten, and each read returns the next eight bits of the LFSR output. Disabling the block freezes both the LFSR and any partly gathered byte. Enabling it again resumes the stream where it stopped.

Top module: `rng_reg_block`

## Requirements
- R1: After reset, offset 0 reads 0x40, offset 1 reads 0x00 and the enable bit is 0.
- R2: Bit 6 of offset 0 always reads 1, whatever was written. Bits 7 and 5..1 of offset 0 always read 0.
- R3: A write to offset 0 stores write-data bit 0 as the enable bit. The new value reads back at bit 0 of offset 0 from the next cycle on.
- R4: Bit 0 of offset 1 is the ready flag. Bits 7..1 of offset 1 always read 0.
- R5: The ready flag sets after exactly 8 clock cycles in which the block is enabled and the flag is clear. It then reads 1 from the following cycle on.
- R6: Each byte holds eight consecutive LFSR output bits, with the first bit in bit 7. The LFSR starts at 0xACE1. Each shift moves the state left and inserts, at bit 0, the XOR of state bits 15, 13, 12 and 10. That same XOR value is the output bit.
- R7: A read of offset 2 returns the held byte and clears the ready flag at the end of that cycle. A second read in the next cycle still shows ready = 0.
- R8: While the enable bit is 0, no bits are gathered and the ready flag stays 0 once the held byte has been read. A partly gathered byte and the LFSR state are kept until collection resumes.
- R9: While the ready flag is set, collection stalls. The held byte does not change, however long it waits, until offset 2 is read.
- R10: Writes to offsets 1, 2 and 3 change nothing. Offset 3 reads 0x00.
- R11: Reads of offsets 0 and 1 leave the ready flag and the held byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid in the cycle the read strobe is high |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 16-bit LFSR with taps 0xB400 and seed 0xACE1. With these values the bench can compute every byte from an LFSR model of its own. Because the bytes are 8 bits wide, the exact cycle in which the ready flag sets can be probed by reading offset 1 in every cycle. Together, these values make it possible to check that a pause in collection, whether from disable or from a held byte, loses no bit of the stream.

// File: rtl/rng_regs_pkg.sv
package rng_regs_pkg;
    // register offsets inside the window
    localparam int unsigned OFS_HWCTL = 0;
    localparam int unsigned OFS_FLAGS = 1;
    localparam int unsigned OFS_BYTE  = 2;
    // bit positions
    localparam int unsigned PRESENT_BIT = 6;
    localparam int unsigned ENABLE_BIT  = 0;
    localparam int unsigned READY_BIT   = 0;
endpackage

// File: rtl/rng_lfsr_src.sv
module rng_lfsr_src #(
    parameter int unsigned   LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    output logic bit_o
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    fb;

    always_comb begin
        fb   = ^(st_q.lfsr & LFSR_TAPS);
        st_d = st_q;
        if (shift_en) begin
            st_d.lfsr = {st_q.lfsr[LFSR_W-2:0], fb};
        end
    end

    assign bit_o = fb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    src_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.lfsr));

    // R6
    src_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.lfsr[0] == $past(bit_o));
endmodule

// File: rtl/rng_byte_gather.sv
module rng_byte_gather #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_i,
    input  logic              take,
    output logic              collect_o,
    output logic              ready_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              ready;
    } gat_st_t;

    gat_st_t           st_d, st_q;
    logic              collect;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        collect = enable && !st_q.ready;
        shifted = {st_q.shreg[DATA_W-2:0], bit_i};
        st_d    = st_q;
        if (take) begin
            st_d.ready = 1'b0;
        end
        if (collect) begin
            st_d.shreg = shifted;
            if (st_q.cnt == LAST_CNT) begin
                st_d.cnt   = '0;
                st_d.data  = shifted;
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    assign collect_o = collect;
    assign ready_o   = st_q.ready;
    assign byte_o    = st_q.data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.ready);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && !take) |=> (st_q.ready && $stable(st_q.data)));

    // R5
    byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> $past(st_q.cnt) == LAST_CNT);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(st_q.cnt) && $stable(st_q.shreg)));
endmodule

// File: rtl/rng_reg_decode.sv
module rng_reg_decode #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              enable_o,
    output logic              take_o,
    output logic [DATA_W-1:0] rdata_o
);
    import rng_regs_pkg::*;

    localparam logic [ADDR_W-1:0] A_HW   = ADDR_W'(OFS_HWCTL);
    localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(OFS_FLAGS);
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(OFS_BYTE);

    typedef struct packed {
        logic en;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    wdata_unused;

    assign wdata_unused = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (we_i && addr_i == A_HW) begin
            st_d.en = wdata_i[ENABLE_BIT];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_HW) begin
            rdata_o[PRESENT_BIT] = 1'b1;
            rdata_o[ENABLE_BIT]  = st_q.en;
        end else if (addr_i == A_FLG) begin
            rdata_o[READY_BIT] = ready_i;
        end else if (addr_i == A_BYTE) begin
            rdata_o = byte_i;
        end
    end

    assign take_o   = re_i && addr_i == A_BYTE;
    assign enable_o = st_q.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_HW) |=> enable_o == $past(wdata_i[ENABLE_BIT]));

    // R10
    enable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == A_HW) |=> $stable(enable_o));
endmodule

// File: rtl/rng_reg_block.sv
module rng_reg_block #(
    parameter int unsigned       ADDR_W    = 2,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              enable;
    logic              take;
    logic              collect;
    logic              src_bit;
    logic              ready;
    logic [DATA_W-1:0] held_byte;

    rng_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .we_i     (bus_we),
        .re_i     (bus_re),
        .ready_i  (ready),
        .byte_i   (held_byte),
        .enable_o (enable),
        .take_o   (take),
        .rdata_o  (bus_rdata)
    );

    rng_lfsr_src #(.LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (collect),
        .bit_o    (src_bit)
    );

    rng_byte_gather #(.DATA_W(DATA_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bit_i     (src_bit),
        .take      (take),
        .collect_o (collect),
        .ready_o   (ready),
        .byte_o    (held_byte)
    );
endmodule

// File: tb/test_rng_reg_block.sv
`timescale 1ns/1ps
module test_rng_reg_block;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [15:0] model = 16'hACE1;

    always #5 clk = ~clk;

    rng_reg_block i_rng_reg_block (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    // R6: independent LFSR model, first bit lands in bit 7
    function automatic logic [7:0] next_byte();
        logic [7:0] b = '0;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb    = model[15] ^ model[13] ^ model[12] ^ model[10];
            model = {model[14:0], fb};
            b     = {b[6:0], fb};
        end
        return b;
    endfunction

    // driver tasks start and end 1 ns after a rising edge
    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        bus_re   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    // monitor: compares read data at the falling edge of each read cycle
    always @(negedge clk) begin
        if (rst_n && bus_re) begin
            logic [7:0] e;
            string      t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, actual %02h expected none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: addr %0d actual %02h expected %02h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_read(2'd0, 8'h40, "R1 hw status");
        bus_read(2'd1, 8'h00, "R1 flags");

        // R5 ready timing after enable (R3 read-back)
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, 8'h41, "R3 enable readback");
        for (int i = 0; i < 7; i++) bus_read(2'd1, 8'h00, "R5 not yet ready");
        bus_read(2'd1, 8'h01, "R5 ready after 8 bits");
        // R11 status reads do not consume
        bus_read(2'd1, 8'h01, "R11 still ready");
        bus_read(2'd0, 8'h41, "R11 hw read");
        b = next_byte();
        bus_read(2'd2, b, "R6 first byte");
        // R7 cleared
        bus_read(2'd1, 8'h00, "R7 cleared after take");
        // R4 / R5 again: 7 more zero cycles then set
        for (int i = 0; i < 7; i++) bus_read(2'd1, 8'h00, "R5 refill");
        bus_read(2'd1, 8'h01, "R4 ready bit only");
        // R9 held byte waits
        idle(40);
        b = next_byte();
        bus_read(2'd2, b, "R9 held byte unchanged");
        bus_read(2'd2, b, "R7 second read same byte");

        // R10 writes to other offsets
        idle(20);
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, 8'h00, "R10 offset 3 reads zero");
        bus_read(2'd1, 8'h01, "R10 flags unchanged");
        bus_read(2'd0, 8'h41, "R10 enable unchanged");
        b = next_byte();
        bus_read(2'd2, b, "R10 byte unchanged");

        // R2 presence ignores writes (disable here: one bit gathered in this cycle)
        bus_write(2'd0, 8'h00);
        bus_read(2'd0, 8'h40, "R2 presence with enable 0");
        idle(30);
        // R8 disabled: nothing gathered
        bus_read(2'd1, 8'h00, "R8 no ready while disabled");
        bus_write(2'd0, 8'hBE);
        bus_read(2'd0, 8'h40, "R2 reserved bits zero");
        idle(10);
        bus_read(2'd1, 8'h00, "R8 still not ready");
        // re-enable: 7 remaining bits
        bus_write(2'd0, 8'hFF);
        for (int i = 0; i < 6; i++) bus_read(2'd1, 8'h00, "R8 partial resume");
        bus_read(2'd0, 8'h41, "R2 write ff reads 41");
        bus_read(2'd1, 8'h01, "R8 partial byte completes");
        b = next_byte();
        bus_read(2'd2, b, "R8 stream continuity");

        // a few more bytes
        for (int k = 0; k < 4; k++) begin
            idle(9);
            b = next_byte();
            bus_read(2'd2, b, "R6 stream byte");
        end

        idle(2);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule